// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Controller

This block watches a set of wired interrupt inputs and converts each one into a single posted write message for a processor. A message carries a 16-bit destination address and a data word. Every input has a redirection entry that holds its mask, polarity, trigger mode, message data value and destination. Software reaches these entries indirectly. It writes an internal register index to a select register and then reads or writes the chosen register through a data window. A third register takes end-of-interrupt writes, which re-arm level-triggered inputs.

The message leaves the block on a valid/ready stream. While `msg_valid` is high and `msg_ready` is low, the block holds address and data unchanged and captures no new message. A new message may be captured in the same cycle that the current one is accepted. Inputs are assumed synchronous to `clk`. Each input is registered once before polarity is applied.

Top module: `irq_redirect`

## Requirements
- R1: The bus offset 0x00 is the select register, and it reads back the 8-bit index last written. A read or write at offset 0x10 acts on the internal register that the select value names. Any other offset reads zero, apart from 0x40, which is write-only.
- R2: Internal index 0x01 is read-only. It returns `VER` in bits 7:0 and the number of lines minus one in bits 23:16. Writes to it are ignored.
- R3: Line n has its low entry word at index 0x10+2n and its high word at 0x11+2n. The low word holds the data value in bits DW-1:0, active-low polarity in bit 13, level trigger in bit 15 (clear selects edge) and mask in bit 16. The high word holds the destination ID in bits 31:24 and the extended ID in bits 23:16. All other bits read zero. Indices beyond the last line, and indices that map to nothing, read zero and ignore writes.
- R4: After reset, every low word reads 0x00010000, every high word reads zero, no message is valid and no input is pending or in service.
- R5: A message carries `msg_addr` = {destination ID, extended ID} and `msg_data` = the data value of its line.
- R6: An unmasked edge line sends one message for each inactive-to-active transition of its input, after polarity is applied. `msg_valid` rises after the third rising clock edge that follows the input change, provided the output is free.
- R7: A level line that sends a message becomes in service. It sends nothing more until it receives a matching end-of-interrupt.
- R8: A write to offset 0x40 clears the in-service state of every line whose data value equals the written bits DW-1:0. If the input is still active, one new message follows. A value that matches no line changes nothing.
- R9: An edge that arrives while its line is masked stays pending and is sent once the line is unmasked. A masked level line sends nothing, and it sends one message when it is unmasked while still active.
- R10: When several lines request a message in the same cycle, the lowest-numbered line is served first.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NL | Interrupt input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte offset (select 0x00, window 0x10, end-of-interrupt 0x40) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 16 | Message destination {ID, extended ID} |
| msg_data | output | DW | Message data value |

## Verification
The bench builds the block with four lines and 8-bit data values. With four lines, index 0x18 lies inside the select range but past the last entry, so the out-of-range write and read of R3 can be tested. Four lines are also enough to show the priority order across non-adjacent lines while the output is stalled. A behavioural model follows each clock and predicts the exact cycle of every message. The active-low, masked-pending and end-of-interrupt reissue cases all have visible timing.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [6:0] OFS_SEL = 7'h00;
  localparam logic [6:0] OFS_WIN = 7'h10;
  localparam logic [6:0] OFS_EOI = 7'h40;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_BASE = 8'h10;
  localparam int POL_B  = 13;
  localparam int LVL_B  = 15;
  localparam int MASK_B = 16;
endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int NL = 8,
  parameter int DW = 8,
  parameter logic [7:0] VER = 8'h11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [6:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [NL-1:0]          mask_o,
  output logic [NL-1:0]          pol_o,
  output logic [NL-1:0]          lvl_o,
  output logic [NL-1:0][DW-1:0]  dat_o,
  output logic [NL-1:0][15:0]    dst_o,
  output logic [NL-1:0]          eoi_o
);
  localparam int LW = (NL > 1) ? $clog2(NL) : 1;
  localparam logic [8:0] IDX_END = 9'(16 + 2 * NL);

  logic [7:0]  sel_q;
  logic [7:0]  off;
  logic [LW-1:0] line_idx;
  logic        win_hit, wr_win;
  logic [31:0] win_rd, lo_w;

  assign off      = sel_q - IDX_BASE;
  assign line_idx = off[LW:1];
  assign win_hit  = (sel_q >= IDX_BASE) && ({1'b0, sel_q} < IDX_END);
  assign wr_win   = bus_wr && (bus_addr == OFS_WIN) && win_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mask_o <= '1;
      pol_o  <= '0;
      lvl_o  <= '0;
      dat_o  <= '0;
      dst_o  <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_SEL) sel_q <= bus_wdata[7:0];
      for (int i = 0; i < NL; i++) begin
        if (wr_win && line_idx == LW'(i)) begin
          if (sel_q[0]) begin
            dst_o[i] <= bus_wdata[31:16];
          end else begin
            dat_o[i]  <= bus_wdata[DW-1:0];
            pol_o[i]  <= bus_wdata[POL_B];
            lvl_o[i]  <= bus_wdata[LVL_B];
            mask_o[i] <= bus_wdata[MASK_B];
          end
        end
      end
    end
  end

  always_comb begin
    lo_w = '0;
    lo_w[DW-1:0] = dat_o[line_idx];
    lo_w[POL_B]  = pol_o[line_idx];
    lo_w[LVL_B]  = lvl_o[line_idx];
    lo_w[MASK_B] = mask_o[line_idx];
    if (sel_q == IDX_VER)  win_rd = {8'h00, 8'(NL - 1), 8'h00, VER};
    else if (!win_hit)     win_rd = '0;
    else if (sel_q[0])     win_rd = {dst_o[line_idx], 16'h0000};
    else                   win_rd = lo_w;
    case (bus_addr)
      OFS_SEL: bus_rdata = {24'h0, sel_q};
      OFS_WIN: bus_rdata = win_rd;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NL; g++) begin : g_eoi
    assign eoi_o[g] = bus_wr && (bus_addr == OFS_EOI) && (bus_wdata[DW-1:0] == dat_o[g]);
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(mask_o) && $stable(dat_o) && $stable(dst_o));
endmodule

// File: rtl/irq_redir_line.sv
module irq_redir_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic mask_i,
  input  logic pol_i,
  input  logic lvl_i,
  input  logic eoi_i,
  input  logic gnt_i,
  output logic req_o
);
  logic in_q, act_q, pend_q, insvc_q, act, rise;

  assign act  = in_q ^ pol_i;
  assign rise = act & ~act_q;
  assign req_o = lvl_i ? (act & ~mask_i & ~insvc_q) : (pend_q & ~mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      in_q    <= irq_i;
      act_q   <= act;
      pend_q  <= (pend_q & ~gnt_i) | (rise & ~lvl_i);
      insvc_q <= (insvc_q & ~eoi_i) | (gnt_i & lvl_i);
    end
  end

  // R10
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n) gnt_i |-> req_o);
  // R7
  insvc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_i && lvl_i |=> insvc_q);
endmodule

// File: rtl/irq_redir_msg.sv
module irq_redir_msg #(
  parameter int NL = 8,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NL-1:0]         req_i,
  input  logic [NL-1:0][DW-1:0] dat_i,
  input  logic [NL-1:0][15:0]   dst_i,
  output logic [NL-1:0]         gnt_o,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [15:0]           msg_addr,
  output logic [DW-1:0]         msg_data
);
  localparam int LW = (NL > 1) ? $clog2(NL) : 1;

  logic [LW-1:0] pick;
  logic          take;

  always_comb begin
    pick = '0;
    for (int i = NL - 1; i >= 0; i--) if (req_i[i]) pick = LW'(i);
  end

  assign take  = (!msg_valid || msg_ready) && (|req_i);
  assign gnt_o = take ? (NL'(1) << pick) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (take) begin
      msg_valid <= 1'b1;
      msg_addr  <= dst_i[pick];
      msg_data  <= dat_i[pick];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
  // R10
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (req_i & (gnt_o - NL'(1))) == '0);
  // R10
  gnt_one_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o));
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect #(
  parameter int NL = 8,
  parameter int DW = 8,
  parameter logic [7:0] VER = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic          bus_wr,
  input  logic [6:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [15:0]   msg_addr,
  output logic [DW-1:0] msg_data
);
  logic [NL-1:0]         mask, pol, lvl, eoi, req, gnt;
  logic [NL-1:0][DW-1:0] dat;
  logic [NL-1:0][15:0]   dst;

  irq_redir_regs #(.NL(NL), .DW(DW), .VER(VER)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mask_o(mask), .pol_o(pol),
    .lvl_o(lvl), .dat_o(dat), .dst_o(dst), .eoi_o(eoi));

  for (genvar g = 0; g < NL; g++) begin : g_line
    irq_redir_line u_line (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_in[g]), .mask_i(mask[g]),
      .pol_i(pol[g]), .lvl_i(lvl[g]), .eoi_i(eoi[g]), .gnt_i(gnt[g]),
      .req_o(req[g]));
  end

  irq_redir_msg #(.NL(NL), .DW(DW)) u_msg (
    .clk(clk), .rst_n(rst_n), .req_i(req), .dat_i(dat), .dst_i(dst),
    .gnt_o(gnt), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  // R4
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(|req));
endmodule

// File: tb/irq_redirect_tb.sv
module irq_redirect_tb;
  localparam int NL = 4;
  localparam int DW = 8;
  localparam logic [31:0] MSK = 32'h0001_0000;
  localparam logic [31:0] LVL = 32'h0000_8000;
  localparam logic [31:0] POL = 32'h0000_2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic msg_valid, msg_ready = 1'b1;
  logic [15:0] msg_addr;
  logic [DW-1:0] msg_data;

  int nchk = 0, nbad = 0;
  bit done = 1'b0;
  logic [7:0]  got_d[$];
  logic [15:0] got_a[$];

  // behavioural reference state
  logic [7:0]  m_sel;
  logic [7:0]  m_dat[NL];
  logic [15:0] m_dst[NL];
  bit m_msk[NL], m_pol[NL], m_lvl[NL], m_in[NL], m_actp[NL], m_pend[NL], m_svc[NL];
  bit m_val;
  logic [15:0] m_addr;
  logic [7:0]  m_data;

  irq_redirect #(.NL(NL), .DW(DW), .VER(8'h11)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic mreset();
    m_sel = '0; m_val = 0; m_addr = '0; m_data = '0;
    for (int i = 0; i < NL; i++) begin
      m_dat[i] = '0; m_dst[i] = '0; m_msk[i] = 1; m_pol[i] = 0; m_lvl[i] = 0;
      m_in[i] = 0; m_actp[i] = 0; m_pend[i] = 0; m_svc[i] = 0;
    end
  endtask

  initial mreset();

  always @(posedge clk) begin
    if (!rst_n) mreset();
    else begin
      bit act[NL], rise[NL], req[NL];
      int g;
      g = -1;
      for (int i = 0; i < NL; i++) begin
        act[i]  = m_in[i] ^ m_pol[i];
        rise[i] = act[i] && !m_actp[i];
        req[i]  = m_lvl[i] ? (act[i] && !m_msk[i] && !m_svc[i]) : (m_pend[i] && !m_msk[i]);
      end
      if (!m_val || msg_ready)
        for (int i = NL - 1; i >= 0; i--) if (req[i]) g = i;
      if (g >= 0) begin
        m_val = 1; m_addr = m_dst[g]; m_data = m_dat[g];
      end else if (msg_ready) m_val = 0;
      for (int i = 0; i < NL; i++) begin
        bit hit;
        hit = bus_wr && bus_addr == 7'h40 && bus_wdata[7:0] == m_dat[i];
        m_svc[i]  = (m_svc[i] && !hit) || (g == i && m_lvl[i]);
        m_pend[i] = (m_pend[i] && g != i) || (rise[i] && !m_lvl[i]);
      end
      if (bus_wr && bus_addr == 7'h10 && m_sel >= 8'h10 && int'(m_sel) < 16 + 2 * NL) begin
        int ln;
        ln = (int'(m_sel) - 16) / 2;
        if (m_sel[0]) m_dst[ln] = bus_wdata[31:16];
        else begin
          m_dat[ln] = bus_wdata[7:0]; m_pol[ln] = bus_wdata[13];
          m_lvl[ln] = bus_wdata[15];  m_msk[ln] = bus_wdata[16];
        end
      end
      if (bus_wr && bus_addr == 7'h00) m_sel = bus_wdata[7:0];
      for (int i = 0; i < NL; i++) begin
        m_actp[i] = act[i]; m_in[i] = irq_in[i];
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R11 model valid", 32'(msg_valid), 32'(m_val));
      if (m_val) begin
        chk("R5 model addr", 32'(msg_addr), 32'(m_addr));
        chk("R5 model data", 32'(msg_data), 32'(m_data));
      end
      if (msg_valid && msg_ready) begin
        got_d.push_back(msg_data);
        got_a.push_back(msg_addr);
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wwin(input logic [7:0] idx, input logic [31:0] d);
    wr(7'h00, {24'h0, idx});
    wr(7'h10, d);
  endtask

  task automatic rwin(input logic [7:0] idx, output logic [31:0] v);
    wr(7'h00, {24'h0, idx});
    rd(7'h10, v);
  endtask

  task automatic cfg(input int ln, input logic [31:0] lo, input logic [31:0] hi);
    wwin(8'(16 + 2 * ln), lo);
    wwin(8'(17 + 2 * ln), hi);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    logic [7:0] hold_d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R4 reset state
    chk("R4 valid low", 32'(msg_valid), 32'h0);
    for (int i = 0; i < NL; i++) begin
      rwin(8'(16 + 2 * i), v); chk("R4 low word", v, 32'h0001_0000);
      rwin(8'(17 + 2 * i), v); chk("R4 high word", v, 32'h0);
    end
    // R2 version
    rwin(8'h01, v); chk("R2 version", v, 32'h0003_0011);
    wwin(8'h01, 32'hFFFF_FFFF);
    rwin(8'h01, v); chk("R2 write ignored", v, 32'h0003_0011);
    // R1 select readback and unused offset
    wr(7'h00, 32'h0000_0013);
    rd(7'h00, v); chk("R1 select readback", v, 32'h13);
    rd(7'h20, v); chk("R1 unused offset", v, 32'h0);
    // R3 field layout
    wwin(8'h10, 32'hFFFF_FFFF);
    rwin(8'h10, v); chk("R3 low fields", v, 32'h0001_A0FF);
    wwin(8'h11, 32'hFFFF_FFFF);
    rwin(8'h11, v); chk("R3 high fields", v, 32'hFFFF_0000);
    wwin(8'h18, 32'hFFFF_FFFF);
    rwin(8'h18, v); chk("R3 beyond last line", v, 32'h0);
    rwin(8'h17, v); chk("R3 last line untouched", v, 32'h0);
    rwin(8'h05, v); chk("R3 unmapped index", v, 32'h0);

    // R6 edge, active high, with R5 content
    cfg(0, 32'h40, 32'h1234_0000);
    idle(4);
    n0 = got_d.size();
    @(negedge clk); irq_in[0] = 1'b1;
    @(negedge clk); #1 chk("R6 latency edge1", 32'(msg_valid), 32'h0);
    @(negedge clk); #1 chk("R6 latency edge2", 32'(msg_valid), 32'h0);
    @(negedge clk); #1 chk("R6 latency edge3", 32'(msg_valid), 32'h1);
    idle(4); irq_in[0] = 1'b0; idle(10);
    chk("R6 one message per edge", 32'(got_d.size() - n0), 32'h1);
    chk("R5 data", 32'(got_d[n0]), 32'h40);
    chk("R5 address", 32'(got_a[n0]), 32'h1234);

    // R6 active-low edge
    irq_in[1] = 1'b1;
    cfg(1, POL | 32'h41, 32'h5678_0000);
    idle(4);
    n0 = got_d.size();
    irq_in[1] = 1'b0; idle(10);
    irq_in[1] = 1'b1; idle(10);
    chk("R6 active-low count", 32'(got_d.size() - n0), 32'h1);
    chk("R6 active-low data", 32'(got_d[n0]), 32'h41);

    // R7 / R8 level
    cfg(2, LVL | 32'h42, 32'h9ABC_0000);
    n0 = got_d.size();
    irq_in[2] = 1'b1; idle(20);
    chk("R7 single level message", 32'(got_d.size() - n0), 32'h1);
    wr(7'h40, 32'h99); idle(10);
    chk("R8 unmatched ignored", 32'(got_d.size() - n0), 32'h1);
    wr(7'h40, 32'h42); idle(10);
    chk("R8 reissue while active", 32'(got_d.size() - n0), 32'h2);
    irq_in[2] = 1'b0; idle(2);
    wr(7'h40, 32'h42); idle(10);
    chk("R8 no reissue when idle", 32'(got_d.size() - n0), 32'h2);

    // R9 masked edge then masked level
    cfg(3, MSK | 32'h43, 32'h0);
    n0 = got_d.size();
    irq_in[3] = 1'b1; idle(3); irq_in[3] = 1'b0; idle(10);
    chk("R9 masked edge silent", 32'(got_d.size() - n0), 32'h0);
    wwin(8'h16, 32'h43); idle(10);
    chk("R9 pending edge delivered", 32'(got_d.size() - n0), 32'h1);
    wwin(8'h14, MSK | LVL | 32'h42);
    irq_in[2] = 1'b1; idle(10);
    chk("R9 masked level silent", 32'(got_d.size() - n0), 32'h1);
    wwin(8'h14, LVL | 32'h42); idle(10);
    chk("R9 unmask while active", 32'(got_d.size() - n0), 32'h2);
    irq_in[2] = 1'b0; idle(2);
    wr(7'h40, 32'h42); idle(5);

    // R10 priority under R11 back-pressure
    msg_ready = 1'b0;
    n0 = got_d.size();
    irq_in[3] = 1'b1; irq_in[1] = 1'b0; irq_in[0] = 1'b1;
    idle(8);
    #1 chk("R11 valid held", 32'(msg_valid), 32'h1);
    hold_d = msg_data;
    chk("R10 lowest first", 32'(hold_d), 32'h40);
    idle(3);
    #1 chk("R11 data stable", 32'(msg_data), 32'(hold_d));
    msg_ready = 1'b1; idle(10);
    chk("R10 three messages", 32'(got_d.size() - n0), 32'h3);
    if (got_d.size() - n0 == 3) begin
      chk("R10 order 1", 32'(got_d[n0 + 1]), 32'h41);
      chk("R10 order 2", 32'(got_d[n0 + 2]), 32'h43);
    end
    irq_in = 4'b0010; idle(5);

    done = 1'b1;
    finish_run();
  end
endmodule